// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer with Banked Flags

This block sequences interrupt entry and return for a small 8-bit core with a 12-bit program counter. It latches rising edges on a set of maskable request lines and on one non-maskable request line. At every instruction boundary the decoder signals, it decides whether to divert the core. On entry it saves the current program counter on a six-level hardware return stack and emits the handler address with a one-cycle load strobe. It also moves the active carry/zero flag bank to the bank of the new mode, and holds instruction fetch for a fixed number of cycles.

The core keeps three carry/zero flag banks in the datapath: normal, interrupt and non-maskable. This block only drives the select that names the active bank, so flags never travel through the stack. A return-from-interrupt strobe pops the saved address and restores the previous bank. A non-maskable handler that interrupted a maskable handler returns to the interrupt bank; every other return goes to the normal bank, which also lifts the inhibit on maskable requests. Plain subroutine call and return strobes share the same stack.

Top module: `irq_entry_seq`

## Requirements
- R1: After a synchronous reset, `flag_bank` is 0 (normal), and `pc_load`, `fetch_hold` and `stk_err` are 0.
- R2: A rising edge on `irq_req[i]` sets a pending latch for source i. That source enters its handler on the clock edge where `insn_done` is 1 only if all of these hold: `int_en` is 1, `flag_bank` is 0, no hold is active, and the latch was set at least one edge earlier. With `int_en` at 0, a boundary leaves the bank and `pc_load` unchanged.
- R3: Among pending maskable sources, the lowest index wins, and its handler address is 0xFF6 minus 2*i. A pending non-maskable request beats any maskable one at the same boundary.
- R4: A pending non-maskable request enters its handler at a boundary from the normal or the interrupt bank, never from the non-maskable bank. It drives `pc_out` to 0xFFC and `flag_bank` to 2.
- R5: Every entry takes place on one clock edge, with these effects:
  - `pc_in` is pushed on the stack.
  - The pending latch of the accepted source is cleared; other latches are kept.
  - `pc_out` takes the handler address.
  - `pc_load` is 1 for exactly the next cycle.
- R6: `fetch_hold` is 1 for the 3 cycles that follow an entry edge. While it is 1, boundary, return and call strobes are ignored.
- R7: While `flag_bank` is 1 or 2, maskable requests are inhibited but stay pending. They are taken at the first boundary after the return to the normal bank.
- R8: `reti_req` pops the stack into `pc_out` with a `pc_load` pulse. The bank goes from 1 to 0. From 2 it goes to 1 if the non-maskable entry was made from bank 1, and to 0 otherwise. In bank 0 it pops without a bank change. `ret_req` pops without a bank change, and `call_req` pushes `pc_in` without a load.
- R9: The stack is last-in first-out and six entries deep. A push onto a full stack drops the oldest entry. A pop of an empty stack returns the value popped last. Either event sets `stk_err`, which stays 1 until reset.
- R10: `flag_bank` encodes normal as 0, interrupt as 1 and non-maskable as 2, and never shows 3. Strobes are served in this order: non-maskable entry, maskable entry, `reti_req`, `ret_req`, `call_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 4 | Maskable request lines, rising-edge latched |
| nmi_req | input | 1 | Non-maskable request line, rising-edge latched |
| int_en | input | 1 | Global enable for maskable requests |
| insn_done | input | 1 | Instruction boundary strobe |
| reti_req | input | 1 | Return-from-interrupt strobe |
| ret_req | input | 1 | Plain return strobe (pop only) |
| call_req | input | 1 | Subroutine call strobe (push only) |
| pc_in | input | 12 | Current program counter from the core |
| pc_out | output | 12 | Program counter value to load |
| pc_load | output | 1 | One-cycle strobe: load `pc_out` into the PC |
| fetch_hold | output | 1 | Fetch stall during the entry sequence |
| flag_bank | output | 2 | Active carry/zero bank select |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
Every result is registered and appears one edge after the strobe that causes it. This covers `pc_out`, `pc_load`, `flag_bank`, `fetch_hold` and `stk_err`. A request edge needs one more edge before a boundary can take it, so the bench raises a request line one full cycle ahead of the boundary strobe. The bench drives strobes on the falling edge, lets one rising edge pass, and compares on the next falling edge. Its behavioural model advances on each rising edge, and the model and the DUT are compared on every falling edge. Strobes meant to be ignored are placed inside the three-cycle hold window.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int PC_W = 12;
    localparam logic [PC_W-1:0] NMI_VEC     = 12'hFFC;
    localparam logic [PC_W-1:0] INT_VEC_TOP = 12'hFF6;

    typedef enum logic [1:0] {
        BANK_NORM = 2'd0,
        BANK_INT  = 2'd1,
        BANK_NMI  = 2'd2
    } bank_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ENTER_NMI,
        OP_ENTER_INT,
        OP_RETI,
        OP_RET,
        OP_CALL
    } op_e;

    typedef struct packed {
        logic            push;
        logic            pop;
        logic [PC_W-1:0] data;
    } stk_cmd_t;

    // Handler address of maskable source idx: descending even addresses.
    function automatic logic [PC_W-1:0] int_vector(input logic [PC_W-1:0] idx);
        return INT_VEC_TOP - (idx << 1);
    endfunction

endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch
    import irq_entry_pkg::*;
#(
    parameter int N_SRC = 4,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] clr,
    input  logic             nmi,
    input  logic             nmi_clr,
    output logic             nmi_pend,
    output logic             sel_valid,
    output logic [IDX_W-1:0] sel_idx
);

    logic [N_SRC-1:0] pend;
    logic             nmi_prev;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic prev_q;
        logic pend_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= req[g];
                pend_q <= (pend_q & ~clr[g]) | (req[g] & ~prev_q);
            end
        end
        assign pend[g] = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi;
            nmi_pend <= (nmi_pend & ~nmi_clr) | (nmi & ~nmi_prev);
        end
    end

    // Lowest index wins.
    always_comb begin
        sel_valid = 1'b0;
        sel_idx   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                sel_valid = 1'b1;
                sel_idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack
    import irq_entry_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  stk_cmd_t        cmd,
    output logic [PC_W-1:0] pop_data,
    output logic            err
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [PC_W-1:0]  mem [DEPTH];
    logic [CNT_W-1:0] count;

    // Empty stack yields the slot that was popped last.
    assign pop_data = (count == '0) ? mem[0] : mem[count - 1'b1];

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            err   <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (cmd.push) begin
            if (count != FULL) begin
                mem[count] <= cmd.data;
                count      <= count + 1'b1;
            end else begin
                for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i+1];
                mem[DEPTH-1] <= cmd.data;
                err          <= 1'b1;
            end
        end else if (cmd.pop) begin
            if (count != '0) count <= count - 1'b1;
            else             err   <= 1'b1;
        end
    end

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int N_SRC     = 4,
    parameter int ENTRY_CYC = 3,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int CNT_W = $clog2(ENTRY_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             insn_done,
    input  logic             reti_req,
    input  logic             ret_req,
    input  logic             call_req,
    input  logic             int_en,
    input  logic             nmi_pend,
    input  logic             sel_valid,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [PC_W-1:0]  pop_data,
    output bank_e            bank,
    output logic             hold,
    output logic [PC_W-1:0]  pc_out,
    output logic             pc_load,
    output stk_cmd_t         stk_cmd,
    output logic [N_SRC-1:0] clr_src,
    output logic             nmi_clr
);

    op_e              op;
    logic [CNT_W-1:0] cnt;
    logic             nmi_from_int;
    bank_e            ret_bank;

    assign hold = (cnt != '0);

    always_comb begin
        op = OP_NONE;
        if (!hold) begin
            if (insn_done && nmi_pend && bank != BANK_NMI)
                op = OP_ENTER_NMI;
            else if (insn_done && bank == BANK_NORM && int_en && sel_valid)
                op = OP_ENTER_INT;
            else if (reti_req)
                op = OP_RETI;
            else if (ret_req)
                op = OP_RET;
            else if (call_req)
                op = OP_CALL;
        end
    end

    always_comb begin
        stk_cmd.push = (op == OP_ENTER_NMI) || (op == OP_ENTER_INT) || (op == OP_CALL);
        stk_cmd.pop  = (op == OP_RETI) || (op == OP_RET);
        stk_cmd.data = pc_in;
        clr_src      = (op == OP_ENTER_INT) ? (N_SRC'(1) << sel_idx) : '0;
        nmi_clr      = (op == OP_ENTER_NMI);
    end

    always_comb begin
        ret_bank = BANK_NORM;
        if (bank == BANK_NMI && nmi_from_int) ret_bank = BANK_INT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank         <= BANK_NORM;
            nmi_from_int <= 1'b0;
            cnt          <= '0;
            pc_out       <= '0;
            pc_load      <= 1'b0;
        end else begin
            pc_load <= 1'b0;
            if (hold) cnt <= cnt - 1'b1;
            unique case (op)
                OP_ENTER_NMI: begin
                    nmi_from_int <= (bank == BANK_INT);
                    bank         <= BANK_NMI;
                    pc_out       <= NMI_VEC;
                    pc_load      <= 1'b1;
                    cnt          <= CNT_W'(ENTRY_CYC);
                end
                OP_ENTER_INT: begin
                    bank    <= BANK_INT;
                    pc_out  <= int_vector(PC_W'(sel_idx));
                    pc_load <= 1'b1;
                    cnt     <= CNT_W'(ENTRY_CYC);
                end
                OP_RETI: begin
                    bank    <= ret_bank;
                    pc_out  <= pop_data;
                    pc_load <= 1'b1;
                end
                OP_RET: begin
                    pc_out  <= pop_data;
                    pc_load <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int N_SRC     = 4,
    parameter int STK_DEPTH = 6,
    parameter int ENTRY_CYC = 3,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_req,
    input  logic             nmi_req,
    input  logic             int_en,
    input  logic             insn_done,
    input  logic             reti_req,
    input  logic             ret_req,
    input  logic             call_req,
    input  logic [11:0]      pc_in,
    output logic [11:0]      pc_out,
    output logic             pc_load,
    output logic             fetch_hold,
    output logic [1:0]       flag_bank,
    output logic             stk_err
);

    logic             nmi_pend;
    logic             sel_valid;
    logic [IDX_W-1:0] sel_idx;
    logic [N_SRC-1:0] clr_src;
    logic             nmi_clr;
    stk_cmd_t         stk_cmd;
    logic [PC_W-1:0]  pop_data;
    bank_e            bank;

    irq_pend_latch #(.N_SRC(N_SRC)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .req      (irq_req),
        .clr      (clr_src),
        .nmi      (nmi_req),
        .nmi_clr  (nmi_clr),
        .nmi_pend (nmi_pend),
        .sel_valid(sel_valid),
        .sel_idx  (sel_idx)
    );

    irq_ret_stack #(.DEPTH(STK_DEPTH)) u_stack (
        .clk     (clk),
        .rst     (rst),
        .cmd     (stk_cmd),
        .pop_data(pop_data),
        .err     (stk_err)
    );

    irq_entry_ctrl #(.N_SRC(N_SRC), .ENTRY_CYC(ENTRY_CYC)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .insn_done(insn_done),
        .reti_req (reti_req),
        .ret_req  (ret_req),
        .call_req (call_req),
        .int_en   (int_en),
        .nmi_pend (nmi_pend),
        .sel_valid(sel_valid),
        .sel_idx  (sel_idx),
        .pc_in    (pc_in),
        .pop_data (pop_data),
        .bank     (bank),
        .hold     (fetch_hold),
        .pc_out   (pc_out),
        .pc_load  (pc_load),
        .stk_cmd  (stk_cmd),
        .clr_src  (clr_src),
        .nmi_clr  (nmi_clr)
    );

    assign flag_bank = bank;

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
    input logic        clk,
    input logic        rst,
    input logic [11:0] pc_out,
    input logic        pc_load,
    input logic        fetch_hold,
    input logic [1:0]  flag_bank,
    input logic        stk_err
);

    p_bank_legal_r10: assert property (@(posedge clk) disable iff (rst)
        flag_bank != 2'd3);

    p_entry_load_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_hold) |-> pc_load);

    p_hold_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        fetch_hold |=> !pc_load);

    p_nmi_vector_r4: assert property (@(posedge clk) disable iff (rst)
        (flag_bank == 2'd2 && $past(flag_bank) != 2'd2) |-> (pc_load && pc_out == 12'hFFC));

    p_int_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (flag_bank == 2'd1 && $past(flag_bank) == 2'd0) |-> (pc_load && fetch_hold));

    p_bank_change_load_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_bank != $past(flag_bank)) |-> pc_load);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        stk_err |=> stk_err);

endmodule

bind irq_entry_seq irq_entry_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pc_out    (pc_out),
    .pc_load   (pc_load),
    .fetch_hold(fetch_hold),
    .flag_bank (flag_bank),
    .stk_err   (stk_err)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;

    localparam int ENTRY = 3;
    localparam int DEPTH = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  irq_req = '0;
    logic        nmi_req = 1'b0;
    logic        int_en = 1'b0;
    logic        insn_done = 1'b0;
    logic        reti_req = 1'b0;
    logic        ret_req = 1'b0;
    logic        call_req = 1'b0;
    logic [11:0] pc_in = '0;
    logic [11:0] pc_out;
    logic        pc_load;
    logic        fetch_hold;
    logic [1:0]  flag_bank;
    logic        stk_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_entry_seq u_dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .nmi_req(nmi_req),
        .int_en(int_en), .insn_done(insn_done), .reti_req(reti_req),
        .ret_req(ret_req), .call_req(call_req), .pc_in(pc_in),
        .pc_out(pc_out), .pc_load(pc_load), .fetch_hold(fetch_hold),
        .flag_bank(flag_bank), .stk_err(stk_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int       m_bank, m_hold, m_pc, m_last;
    bit       m_load, m_err, m_nfi, m_npend, m_nprev, m_nclr;
    bit [3:0] m_pend, m_prev, m_clr;
    int       m_q[$];

    function automatic void mpush(input int v);
        if (m_q.size() < DEPTH) m_q.push_back(v);
        else begin
            void'(m_q.pop_front());
            m_q.push_back(v);
            m_err = 1;
        end
    endfunction

    function automatic int mpop();
        if (m_q.size() > 0) m_last = m_q.pop_back();
        else m_err = 1;
        return m_last;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_bank = 0; m_hold = 0; m_pc = 0; m_last = 0; m_load = 0;
            m_err = 0; m_nfi = 0; m_npend = 0; m_nprev = 0;
            m_pend = '0; m_prev = '0;
            m_q.delete();
        end else begin
            m_load = 0; m_clr = '0; m_nclr = 0;
            if (m_hold > 0) m_hold--;
            else if (insn_done && m_npend && m_bank != 2) begin
                mpush(int'(pc_in));
                m_nfi = (m_bank == 1); m_bank = 2; m_nclr = 1;
                m_pc = 'hFFC; m_load = 1; m_hold = ENTRY;
            end else if (insn_done && m_bank == 0 && int_en && m_pend != 0) begin
                int src;
                src = 0;
                for (int i = 3; i >= 0; i--) if (m_pend[i]) src = i;
                mpush(int'(pc_in));
                m_bank = 1; m_clr[src] = 1'b1;
                m_pc = 'hFF6 - 2 * src; m_load = 1; m_hold = ENTRY;
            end else if (reti_req) begin
                m_pc = mpop(); m_load = 1;
                if (m_bank == 2) m_bank = m_nfi ? 1 : 0;
                else m_bank = 0;
            end else if (ret_req) begin
                m_pc = mpop(); m_load = 1;
            end else if (call_req) mpush(int'(pc_in));
            m_pend  = (m_pend & ~m_clr) | (irq_req & ~m_prev);
            m_npend = (m_npend & !m_nclr) | (nmi_req & !m_nprev);
            m_prev  = irq_req;
            m_nprev = nmi_req;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R10 model flag_bank", int'(flag_bank), m_bank);
            check("R5 model pc_load", int'(pc_load), int'(m_load));
            check("R5 model pc_out", int'(pc_out), m_pc);
            check("R6 model fetch_hold", int'(fetch_hold), int'(m_hold > 0));
            check("R9 model stk_err", int'(stk_err), int'(m_err));
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic boundary(input int pc);
        insn_done = 1'b1; pc_in = 12'(pc);
        cyc();
        insn_done = 1'b0;
    endtask

    task automatic do_reti();
        reti_req = 1'b1; cyc(); reti_req = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc();
        // R1 reset state
        check("R1 bank", int'(flag_bank), 0);
        check("R1 pc_load", int'(pc_load), 0);
        check("R1 hold", int'(fetch_hold), 0);
        check("R1 stk_err", int'(stk_err), 0);

        // R2 R3 R5 R6 maskable entry of source 2
        int_en = 1'b1; irq_req[2] = 1'b1; cyc();
        boundary('h123);
        check("R2 bank int", int'(flag_bank), 1);
        check("R3 vector src2", int'(pc_out), 'hFF2);
        check("R5 load pulse", int'(pc_load), 1);
        check("R6 hold on", int'(fetch_hold), 1);
        // R6 reti inside hold window is ignored
        do_reti();
        check("R6 reti ignored load", int'(pc_load), 0);
        check("R6 reti ignored bank", int'(flag_bank), 1);
        cyc(3);
        check("R6 hold released", int'(fetch_hold), 0);

        // R7 maskable inhibited in interrupt mode
        irq_req = '0; cyc();
        irq_req[0] = 1'b1; cyc();
        boundary('h150);
        check("R7 inhibited load", int'(pc_load), 0);
        check("R7 inhibited bank", int'(flag_bank), 1);

        // R4 NMI nested inside interrupt handler
        nmi_req = 1'b1; cyc();
        boundary('h200);
        check("R4 nmi bank", int'(flag_bank), 2);
        check("R4 nmi vector", int'(pc_out), 'hFFC);
        nmi_req = 1'b0; irq_req = '0;
        cyc(ENTRY);

        // R8 returns in LIFO order with bank restore
        do_reti();
        check("R8 nmi->int bank", int'(flag_bank), 1);
        check("R8 pop 200", int'(pc_out), 'h200);
        do_reti();
        check("R8 int->norm bank", int'(flag_bank), 0);
        check("R8 pop 123", int'(pc_out), 'h123);

        // R7 pending source 0 taken after return to normal
        boundary('h300);
        check("R7 deferred bank", int'(flag_bank), 1);
        check("R7 deferred vector", int'(pc_out), 'hFF6);
        cyc(ENTRY);
        do_reti();
        check("R8 pop 300", int'(pc_out), 'h300);

        // R2 global disable blocks entry
        int_en = 1'b0; irq_req[1] = 1'b1; cyc();
        boundary('h400);
        check("R2 disabled load", int'(pc_load), 0);
        check("R2 disabled bank", int'(flag_bank), 0);

        // R3 NMI beats maskable at the same boundary
        int_en = 1'b1; nmi_req = 1'b1; cyc();
        boundary('h410);
        check("R3 nmi priority bank", int'(flag_bank), 2);
        check("R3 nmi priority vector", int'(pc_out), 'hFFC);
        nmi_req = 1'b0; cyc(ENTRY);
        do_reti();
        check("R8 nmi->norm bank", int'(flag_bank), 0);
        check("R8 pop 410", int'(pc_out), 'h410);
        boundary('h420);
        check("R3 vector src1", int'(pc_out), 'hFF4);
        irq_req = '0; cyc(ENTRY);
        do_reti();
        check("R8 pop 420", int'(pc_out), 'h420);
        check("R9 no error yet", int'(stk_err), 0);

        // R9 overflow drops oldest, underflow repeats last
        for (int i = 1; i <= 7; i++) begin
            call_req = 1'b1; pc_in = 12'(i); cyc();
        end
        call_req = 1'b0;
        check("R9 overflow flag", int'(stk_err), 1);
        for (int k = 7; k >= 2; k--) begin
            ret_req = 1'b1; cyc(); ret_req = 1'b0;
            check("R9 lifo pop", int'(pc_out), k);
        end
        ret_req = 1'b1; cyc(); ret_req = 1'b0;
        check("R9 empty pop repeats", int'(pc_out), 2);
        check("R10 ret keeps bank", int'(flag_bank), 0);
        cyc(2);
        finish_run();
    end

endmodule